// File: doc/BRIEF.md
# Banked Register File with Direct and Pointer Addressing

This block is the data-memory side of a small accumulator-style core. It holds 8-bit registers split into four banks of 128 locations each. It turns a 7-bit register field taken from an instruction into a physical storage address, and it offers one combinational read port and one clocked write port. In direct mode, two bank-select bits kept in a status register supply the upper address bits. One offset in every bank holds no storage. Any access to that offset is redirected through an 8-bit pointer register, which is extended by a separate indirect-bank bit in the status register.

A small set of core registers is shared across the banks. These are the status register, the pointer, a program-counter-low slot and an interrupt-control slot. An access to one of their offsets reaches the same single copy from every bank, in direct or in indirect mode. The status register and the pointer are held as dedicated flops. The other two shared slots live in bank 0 of the array.

Both ports are plain single-cycle control pins. A request is accepted in the cycle it is presented, and there is no back-pressure, because the register file never stalls. The read port and the write port each resolve their own address using the status and pointer values held before the clock edge.

Top module: `bankreg_file`

## Requirements
- R1: In direct mode (offset not 0), a banked offset reaches physical location {status[6:5], offset}, so each bank 0..3 holds independent storage for the same offset.
- R2: Offset 0 selects indirect mode. The access goes to the location at offset fsr[6:0] in bank {status[7], fsr[7]}.
- R3: When indirect mode resolves to offset 0 itself (fsr[6:0] == 0), a read returns 0x00 and a write changes no register or storage location.
- R4: Offsets 2, 3 (status), 4 (pointer) and 11 are shared. A write to any of them from any bank, direct or indirect, updates one copy, and that copy is read back from every bank.
- R5: A write takes effect at the clock edge, and a read of the same location in the next cycle returns the written data.
- R6: After reset, the status register and the pointer both read 0x00.
- R7: When a read and a write hit the same location in one cycle, the read returns the value held before the write.
- R8: A write that changes the bank bits or the pointer changes the address that later reads and writes resolve, starting in the cycle after the write. The read in the cycle of that write still resolves with the old bank bits and pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the status register and the pointer |
| wr_en | input | 1 | Write request for this cycle |
| wr_off | input | 7 | Register field of the write instruction |
| wr_data | input | 8 | Data to write |
| rd_off | input | 7 | Register field of the read instruction |
| rd_data | output | 8 | Combinational read data |

## Verification
The bench builds the block with its default parameters: 8-bit registers, a 7-bit field and two bank bits. These values make the whole 512-cell array small enough to fill completely before the random phase. Because of that, every location the random phase reads has a known expected value. The defaults also let the 8-bit pointer plus the indirect-bank bit span all four banks exactly. So random pointer and status values reach every bank in both modes, including the self-referencing pointer values 0x00 and 0x80.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFF_W  = 7;
  localparam int unsigned BANK_W = 2;
  localparam int unsigned ADDR_W = OFF_W + BANK_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  // Offsets with fixed meaning inside every bank
  localparam logic [OFF_W-1:0] OFF_INDIR  = 7'd0;
  localparam logic [OFF_W-1:0] OFF_PCLO   = 7'd2;
  localparam logic [OFF_W-1:0] OFF_STATUS = 7'd3;
  localparam logic [OFF_W-1:0] OFF_PTR    = 7'd4;
  localparam logic [OFF_W-1:0] OFF_IRQCTL = 7'd11;

  // Status bit positions used for addressing
  localparam int unsigned ST_BANK_LSB = 5;
  localparam int unsigned ST_IBANK    = 7;

  typedef struct packed {
    logic              self_ref;
    logic              to_status;
    logic              to_ptr;
    logic [ADDR_W-1:0] phys;
  } route_t;

  function automatic logic is_shared(input logic [OFF_W-1:0] o);
    return (o == OFF_INDIR) || (o == OFF_PCLO) || (o == OFF_STATUS) ||
           (o == OFF_PTR) || (o == OFF_IRQCTL);
  endfunction
endpackage

// File: rtl/bankreg_route.sv
module bankreg_route
  import bankreg_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] ptr,
  output route_t            rt
);
  logic              indirect;
  logic [ADDR_W-1:0] raw;
  logic [OFF_W-1:0]  tgt_off;

  always_comb begin
    indirect = (off == OFF_INDIR);
    if (indirect) raw = {status[ST_IBANK], ptr};
    else          raw = {status[ST_BANK_LSB +: BANK_W], off};
    tgt_off      = raw[OFF_W-1:0];
    rt.self_ref  = (tgt_off == OFF_INDIR);
    rt.to_status = (tgt_off == OFF_STATUS);
    rt.to_ptr    = (tgt_off == OFF_PTR);
    rt.phys      = is_shared(tgt_off) ? {{BANK_W{1'b0}}, tgt_off} : raw;
  end
endmodule

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_status,
  input  logic              we_ptr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      ptr_q    <= '0;
    end else begin
      if (we_status) status_q <= wdata;
      if (we_ptr)    ptr_q    <= wdata;
    end
  end
endmodule

// File: rtl/bankreg_mem.sv
module bankreg_mem
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned NPORT = 2;  // 0: read, 1: write

  logic [DATA_W-1:0] status_q, ptr_q, mem_rdata;
  logic [OFF_W-1:0]  port_off [NPORT];
  route_t            port_rt  [NPORT];
  logic              wr_live;

  assign port_off[0] = rd_off;
  assign port_off[1] = wr_off;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    bankreg_route u_route (
      .off    (port_off[p]),
      .status (status_q),
      .ptr    (ptr_q),
      .rt     (port_rt[p])
    );
  end

  assign wr_live = wr_en && !port_rt[1].self_ref;

  bankreg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_status (wr_live && port_rt[1].to_status),
    .we_ptr    (wr_live && port_rt[1].to_ptr),
    .wdata     (wr_data),
    .status_q  (status_q),
    .ptr_q     (ptr_q)
  );

  bankreg_mem u_mem (
    .clk   (clk),
    .we    (wr_live && !port_rt[1].to_status && !port_rt[1].to_ptr),
    .waddr (port_rt[1].phys),
    .wdata (wr_data),
    .raddr (port_rt[0].phys),
    .rdata (mem_rdata)
  );

  always_comb begin
    if (port_rt[0].self_ref)       rd_data = '0;
    else if (port_rt[0].to_status) rd_data = status_q;
    else if (port_rt[0].to_ptr)    rd_data = ptr_q;
    else                           rd_data = mem_rdata;
  end
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk
  import bankreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [OFF_W-1:0]  wr_off,
  input logic [DATA_W-1:0] wr_data,
  input logic [OFF_W-1:0]  rd_off,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] ptr_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $rose(rst_n) |-> (status_q == '0 && ptr_q == '0)); // R6

  AST_SELF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_off == OFF_INDIR && ptr_q[OFF_W-1:0] == OFF_INDIR) |-> rd_data == '0); // R3

  AST_SELF_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_INDIR && ptr_q[OFF_W-1:0] == OFF_INDIR)
      |=> ($stable(status_q) && $stable(ptr_q))); // R3

  AST_STATUS_ANY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_STATUS) |=> status_q == $past(wr_data)); // R4

  AST_PTR_ANY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_PTR) |=> ptr_q == $past(wr_data)); // R4

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off != OFF_INDIR && wr_off != OFF_STATUS && wr_off != OFF_PTR)
      |=> (rd_off != $past(wr_off) || rd_data == $past(wr_data))); // R5
endmodule

bind bankreg_file bankreg_file_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_off   (wr_off),
  .wr_data  (wr_data),
  .rd_off   (rd_off),
  .rd_data  (rd_data),
  .status_q (status_q),
  .ptr_q    (ptr_q)
);

// File: tb/tb_bankreg_file.sv
`timescale 1ns/1ps
module tb_bankreg_file;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_off = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] rd_off = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mem [512];
  logic [7:0] m_status = '0;
  logic [7:0] m_ptr = '0;

  always #4 clk = ~clk;

  bankreg_file dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data)
  );

  function automatic logic shared_off(input logic [6:0] o);
    return o == 7'd0 || o == 7'd2 || o == 7'd3 || o == 7'd4 || o == 7'd11;
  endfunction

  function automatic logic [8:0] raw_addr(input logic [6:0] off);
    if (off == 7'd0) return {m_status[7], m_ptr};
    return {m_status[6:5], off};
  endfunction

  function automatic logic [7:0] exp_read(input logic [6:0] off);
    logic [8:0] r = raw_addr(off);
    if (r[6:0] == 7'd0) return 8'h00;
    if (r[6:0] == 7'd3) return m_status;
    if (r[6:0] == 7'd4) return m_ptr;
    if (shared_off(r[6:0])) return m_mem[{2'b00, r[6:0]}];
    return m_mem[r];
  endfunction

  function automatic string tag_of(input logic [6:0] off);
    logic [8:0] r = raw_addr(off);
    if (r[6:0] == 7'd0) return "R3";
    if (shared_off(r[6:0])) return "R4";
    if (off == 7'd0) return "R2";
    return "R1";
  endfunction

  task automatic model_write(input logic [6:0] off, input logic [7:0] d);
    logic [8:0] r = raw_addr(off);
    if (r[6:0] == 7'd0) return;
    if (r[6:0] == 7'd3) m_status = d;
    else if (r[6:0] == 7'd4) m_ptr = d;
    else if (shared_off(r[6:0])) m_mem[{2'b00, r[6:0]}] = d;
    else m_mem[r] = d;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check the combinational read, then commit the model at posedge
  task automatic step(input logic we, input logic [6:0] woff, input logic [7:0] wd,
                      input logic [6:0] roff, input logic do_chk, input string tag);
    logic [7:0] e;
    @(negedge clk);
    wr_en = we; wr_off = woff; wr_data = wd; rd_off = roff;
    #1;
    e = exp_read(roff);
    if (do_chk) check(tag, rd_data, e);
    @(posedge clk);
    if (we) model_write(woff, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0B2A));
    for (int i = 0; i < 512; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    step(1'b0, 7'd0, 8'h00, 7'd3, 1'b1, "R6 status");
    step(1'b0, 7'd0, 8'h00, 7'd4, 1'b1, "R6 pointer");

    // Fill every bank so all locations are known
    for (int b = 0; b < 4; b++) begin
      step(1'b1, 7'd3, 8'(b << 5), 7'd3, 1'b0, "");
      for (int o = 1; o < 128; o++)
        if (o != 3 && o != 4)
          step(1'b1, 7'(o), 8'($urandom), 7'd0, 1'b0, "");
    end
    step(1'b1, 7'd3, 8'h00, 7'd3, 1'b0, "");

    // R1: same offset, distinct storage per bank
    for (int b = 0; b < 4; b++) begin
      step(1'b1, 7'd3, 8'(b << 5), 7'd3, 1'b0, "");
      step(1'b1, 7'h30, 8'(8'hA0 + b), 7'h30, 1'b1, "R7 old value");
      step(1'b0, 7'd0, 8'h00, 7'h30, 1'b1, "R5 readback");
    end
    for (int b = 0; b < 4; b++) begin
      step(1'b1, 7'd3, 8'(b << 5), 7'd3, 1'b0, "");
      step(1'b0, 7'd0, 8'h00, 7'h30, 1'b1, "R1 bank storage");
    end

    // R4: shared slot written in bank 3 is seen in bank 0
    step(1'b1, 7'd11, 8'h5C, 7'd11, 1'b0, "");
    step(1'b1, 7'd3, 8'h00, 7'd11, 1'b1, "R4 shared from bank 3");
    step(1'b0, 7'd0, 8'h00, 7'd11, 1'b1, "R4 shared in bank 0");

    // R8: bank switch is seen from the next cycle
    step(1'b1, 7'd3, 8'h40, 7'h30, 1'b1, "R8 old bank");
    step(1'b0, 7'd0, 8'h00, 7'h30, 1'b1, "R8 new bank");

    // R2: pointer into bank 3 with the indirect-bank bit
    step(1'b1, 7'd3, 8'h80, 7'd0, 1'b0, "");
    step(1'b1, 7'd4, 8'hB0, 7'd0, 1'b0, "");
    step(1'b1, 7'd0, 8'h77, 7'd0, 1'b1, "R2 indirect read");
    step(1'b0, 7'd0, 8'h00, 7'd0, 1'b1, "R2 indirect write");

    // R3: pointer at the indirect slot itself, both bank halves
    for (int k = 0; k < 2; k++) begin
      step(1'b1, 7'd4, 8'(k << 7), 7'd0, 1'b0, "");
      step(1'b1, 7'd0, 8'hFF, 7'd0, 1'b1, "R3 self read zero");
      step(1'b0, 7'd0, 8'h00, 7'd3, 1'b1, "R3 status untouched");
      step(1'b0, 7'd0, 8'h00, 7'd4, 1'b1, "R3 pointer untouched");
    end

    // Pointer reaching the status register indirectly
    step(1'b1, 7'd4, 8'h83, 7'd0, 1'b0, "");
    step(1'b1, 7'd0, 8'h20, 7'd0, 1'b1, "R4 status via pointer");
    step(1'b0, 7'd0, 8'h00, 7'd3, 1'b1, "R4 status via pointer");

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] wo, ro;
      logic [7:0] wd;
      logic       we;
      int sel = int'($urandom % 8);
      wo = (sel < 2) ? 7'(($urandom % 5)) : 7'($urandom);
      ro = (sel == 7) ? 7'(($urandom % 5)) : 7'($urandom);
      if (sel == 3) wo = 7'd0;
      wd = 8'($urandom);
      we = ($urandom % 4) != 0;
      step(we, wo, wd, ro, 1'b1, tag_of(ro));
    end

    @(negedge clk); wr_en = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule